// File: doc/BRIEF.md
# Indirect Pointer Resolution Stage

This pipeline stage sits between instruction decode and execute. It turns indirect memory operands into final operand addresses. An instruction that needs an indirect load waits here until the memory line holding its pointer word arrives. The stage then picks the pointer word out of that line. If the pointer sits in an auto-incrementing location, the stage adds one to it and writes it back with a store that touches only that word. Finally it prefixes the 3-bit data field to build a 15-bit address. When the instruction also needs an operand, the stage requests that operand's line for the execute stage, then hands the instruction on.

The stage keeps a local generation tag so that it can drop instructions from a squashed path. An instruction carrying a tag that matches neither the local nor the global generation is thrown away. A global restart pulse, or the arrival of an instruction carrying the global tag, brings the local tag up to date. All actions for the instruction at the head of the input take place in the cycle in which it is consumed.

Top module: `ptr_resolve_stage`

## Requirements
- R1: The stage issues nothing and consumes neither the instruction nor a response unless an instruction is valid and the load, store and forward ports are all ready.
- R2: An instruction whose generation tag equals neither the local nor the global generation is consumed, and no load, store or forward is issued for it.
- R3: An instruction whose tag equals only the global generation is accepted, and the local generation takes the global value. After that, an instruction carrying the old local tag is discarded.
- R4: An instruction that needs an indirect load, arriving when no response is valid, is held. It is not consumed and nothing is issued.
- R5: A response whose line address differs from the pointer's line (pointer address bits above the word offset) is consumed. The instruction is held and nothing is issued in that cycle.
- R6: The pointer word is word k of the response line, where k is the pointer address's low log2(words per line) bits. Word k occupies data bits [k*12 +: 12].
- R7: For an auto-increment pointer, the new value is (old + 1) mod 4096. It is written with a store to the pointer's line. The store mask has only bit k set, and the new value sits at word k of the store data while the other words are zero.
- R8: For an indirect instruction, the forwarded final address is {data field, pointer}, using the incremented pointer when auto-increment applies.
- R9: When the instruction needs an operand load, a load is issued in the same cycle as the forward, for line final_address >> log2(words per line).
- R10: An instruction without an indirect load forwards its incoming final address unchanged and consumes no response.
- R11: A restart pulse sets the local generation to the global generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, local generation to 0 |
| restart_i | input | 1 | Global restart pulse |
| gen_global_i | input | GEN_W | Global generation |
| data_field_i | input | FIELD_W | Data field prefix for indirect addresses |
| in_valid_i | input | 1 | Instruction present |
| in_gen_i | input | GEN_W | Instruction generation tag |
| in_need_ind_i | input | 1 | Needs indirect pointer load |
| in_autoinc_i | input | 1 | Pointer is auto-increment |
| in_need_load_i | input | 1 | Needs operand load |
| in_ptr_addr_i | input | ADDR_W | Pointer address |
| in_final_addr_i | input | ADDR_W | Final address for direct instructions |
| in_tag_i | input | TAG_W | Opaque payload passed to execute |
| in_take_o | output | 1 | Instruction consumed |
| rsp_valid_i | input | 1 | Pointer line response valid |
| rsp_line_i | input | LINE_AW | Response line address |
| rsp_data_i | input | LINE_WORDS*WORD_W | Response line data |
| rsp_take_o | output | 1 | Response consumed |
| ld_ready_i | input | 1 | Load port ready |
| ld_valid_o | output | 1 | Operand load request |
| ld_line_o | output | LINE_AW | Operand line address |
| st_ready_i | input | 1 | Store port ready |
| st_valid_o | output | 1 | Pointer write-back request |
| st_line_o | output | LINE_AW | Write-back line address |
| st_data_o | output | LINE_WORDS*WORD_W | Write-back line data |
| st_mask_o | output | LINE_WORDS | Per-word write enable |
| fwd_ready_i | input | 1 | Execute input ready |
| fwd_valid_o | output | 1 | Instruction forwarded |
| fwd_gen_o | output | GEN_W | Forwarded generation tag |
| fwd_need_load_o | output | 1 | Forwarded operand-load flag |
| fwd_final_addr_o | output | ADDR_W | Resolved final address |
| fwd_tag_o | output | TAG_W | Forwarded payload |

## Verification
A wrong local generation shows up at the next instruction whose tag sits near the boundary. A live instruction is then dropped with no forward, or a stale one is forwarded, so the error appears in the cycle that instruction arrives. A wrong offset or increment shows up at once on the forwarded final address and in the store data and mask. A wrong line comparison shows up as a forward taken on a foreign line, or as a valid response that is never consumed, which stalls the stage for good.

// File: rtl/ptr_resolve_stage.sv
module ptr_resolve_stage #(
  parameter int LINE_WORDS = 8,
  parameter int WORD_W     = 12,
  parameter int FIELD_W    = 3,
  parameter int GEN_W      = 4,
  parameter int TAG_W      = 8,
  localparam int OFS_W     = $clog2(LINE_WORDS),
  localparam int ADDR_W    = FIELD_W + WORD_W,
  localparam int LINE_AW   = ADDR_W - OFS_W,
  localparam int LINE_W    = LINE_WORDS * WORD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart_i,
  input  logic [GEN_W-1:0]   gen_global_i,
  input  logic [FIELD_W-1:0] data_field_i,
  input  logic               in_valid_i,
  input  logic [GEN_W-1:0]   in_gen_i,
  input  logic               in_need_ind_i,
  input  logic               in_autoinc_i,
  input  logic               in_need_load_i,
  input  logic [ADDR_W-1:0]  in_ptr_addr_i,
  input  logic [ADDR_W-1:0]  in_final_addr_i,
  input  logic [TAG_W-1:0]   in_tag_i,
  output logic               in_take_o,
  input  logic               rsp_valid_i,
  input  logic [LINE_AW-1:0] rsp_line_i,
  input  logic [LINE_W-1:0]  rsp_data_i,
  output logic               rsp_take_o,
  input  logic               ld_ready_i,
  output logic               ld_valid_o,
  output logic [LINE_AW-1:0] ld_line_o,
  input  logic               st_ready_i,
  output logic               st_valid_o,
  output logic [LINE_AW-1:0] st_line_o,
  output logic [LINE_W-1:0]  st_data_o,
  output logic [LINE_WORDS-1:0] st_mask_o,
  input  logic               fwd_ready_i,
  output logic               fwd_valid_o,
  output logic [GEN_W-1:0]   fwd_gen_o,
  output logic               fwd_need_load_o,
  output logic [ADDR_W-1:0]  fwd_final_addr_o,
  output logic [TAG_W-1:0]   fwd_tag_o
);

  logic [GEN_W-1:0]   gen_q;
  logic               ports_ok, hit_local, hit_global, stale, live;
  logic               line_ok, advance;
  logic [OFS_W-1:0]   ofs;
  logic [LINE_AW-1:0] ptr_line;
  logic [WORD_W-1:0]  old_ptr, new_ptr;
  logic [ADDR_W-1:0]  final_addr;

  assign ports_ok   = in_valid_i && ld_ready_i && st_ready_i && fwd_ready_i;
  assign hit_local  = (in_gen_i == gen_q);
  assign hit_global = (in_gen_i == gen_global_i);
  assign stale      = ports_ok && !hit_local && !hit_global;
  assign live       = ports_ok && (hit_local || hit_global);

  assign ofs      = in_ptr_addr_i[OFS_W-1:0];
  assign ptr_line = in_ptr_addr_i[ADDR_W-1:OFS_W];
  assign line_ok  = (rsp_line_i == ptr_line);
  assign old_ptr  = rsp_data_i[ofs*WORD_W +: WORD_W];
  assign new_ptr  = in_autoinc_i ? WORD_W'(old_ptr + 1'b1) : old_ptr;

  assign final_addr = in_need_ind_i ? {data_field_i, new_ptr} : in_final_addr_i;

  assign advance    = live && (!in_need_ind_i || (rsp_valid_i && line_ok));
  assign rsp_take_o = live && in_need_ind_i && rsp_valid_i;
  assign in_take_o  = stale || advance;

  assign st_valid_o = advance && in_need_ind_i && in_autoinc_i;
  assign st_line_o  = ptr_line;
  assign st_data_o  = LINE_W'(new_ptr) << (ofs * WORD_W);
  assign st_mask_o  = LINE_WORDS'(1) << ofs;

  assign ld_valid_o = advance && in_need_load_i;
  assign ld_line_o  = final_addr[ADDR_W-1:OFS_W];

  assign fwd_valid_o      = advance;
  assign fwd_gen_o        = in_gen_i;
  assign fwd_need_load_o  = in_need_load_i;
  assign fwd_final_addr_o = final_addr;
  assign fwd_tag_o        = in_tag_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gen_q <= '0;
    else if (restart_i || (live && !hit_local))
      gen_q <= gen_global_i;
  end

endmodule

module ptr_resolve_chk #(
  parameter int GEN_W      = 4,
  parameter int LINE_WORDS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  restart_i,
  input logic [GEN_W-1:0]      gen_global_i,
  input logic [GEN_W-1:0]      gen_q,
  input logic                  in_valid_i,
  input logic                  in_take_o,
  input logic                  rsp_take_o,
  input logic                  ld_ready_i,
  input logic                  st_ready_i,
  input logic                  fwd_ready_i,
  input logic                  ld_valid_o,
  input logic                  st_valid_o,
  input logic [LINE_WORDS-1:0] st_mask_o,
  input logic                  fwd_valid_o,
  input logic [GEN_W-1:0]      fwd_gen_o
);

  // R1
  gated_by_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_o || st_valid_o || fwd_valid_o || in_take_o || rsp_take_o) |->
      (in_valid_i && ld_ready_i && st_ready_i && fwd_ready_i));

  // R7
  single_word_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid_o |-> ($countones(st_mask_o) == 1 && fwd_valid_o));

  // R11
  restart_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (gen_q == $past(gen_global_i)));

  // R3
  gen_follows_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid_o && !restart_i) |=> (gen_q == $past(fwd_gen_o)));

  // R5
  held_on_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take_o && !fwd_valid_o) |-> !in_take_o);

endmodule

bind ptr_resolve_stage ptr_resolve_chk #(.GEN_W(GEN_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .gen_global_i(gen_global_i),
  .gen_q(gen_q), .in_valid_i(in_valid_i), .in_take_o(in_take_o), .rsp_take_o(rsp_take_o),
  .ld_ready_i(ld_ready_i), .st_ready_i(st_ready_i), .fwd_ready_i(fwd_ready_i),
  .ld_valid_o(ld_valid_o), .st_valid_o(st_valid_o), .st_mask_o(st_mask_o),
  .fwd_valid_o(fwd_valid_o), .fwd_gen_o(fwd_gen_o)
);

// File: tb/ptr_resolve_stage_bench.sv
module ptr_resolve_stage_bench;
  localparam int LW = 8, WW = 12, AW = 15, LAW = 12, GW = 4, TW = 8;

  logic clk = 0, rst_n = 0, restart = 0;
  logic [GW-1:0] gen_global = 0, in_gen = 0;
  logic [2:0] dfield = 0;
  logic in_valid = 0, need_ind = 0, autoinc = 0, need_load = 0;
  logic [AW-1:0] ptr_addr = 0, final_in = 0;
  logic [TW-1:0] tag = 0;
  logic in_take, rsp_valid = 0, rsp_take;
  logic [LAW-1:0] rsp_line = 0, ld_line, st_line;
  logic [LW*WW-1:0] rsp_data = 0, st_data;
  logic ld_ready = 1, st_ready = 1, fwd_ready = 1;
  logic ld_valid, st_valid, fwd_valid, fwd_need_load;
  logic [LW-1:0] st_mask;
  logic [GW-1:0] fwd_gen;
  logic [AW-1:0] fwd_final;
  logic [TW-1:0] fwd_tag;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ptr_resolve_stage u_ptr_resolve_stage (
    .clk(clk), .rst_n(rst_n), .restart_i(restart), .gen_global_i(gen_global),
    .data_field_i(dfield), .in_valid_i(in_valid), .in_gen_i(in_gen),
    .in_need_ind_i(need_ind), .in_autoinc_i(autoinc), .in_need_load_i(need_load),
    .in_ptr_addr_i(ptr_addr), .in_final_addr_i(final_in), .in_tag_i(tag),
    .in_take_o(in_take), .rsp_valid_i(rsp_valid), .rsp_line_i(rsp_line),
    .rsp_data_i(rsp_data), .rsp_take_o(rsp_take), .ld_ready_i(ld_ready),
    .ld_valid_o(ld_valid), .ld_line_o(ld_line), .st_ready_i(st_ready),
    .st_valid_o(st_valid), .st_line_o(st_line), .st_data_o(st_data),
    .st_mask_o(st_mask), .fwd_ready_i(fwd_ready), .fwd_valid_o(fwd_valid),
    .fwd_gen_o(fwd_gen), .fwd_need_load_o(fwd_need_load),
    .fwd_final_addr_o(fwd_final), .fwd_tag_o(fwd_tag)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [LW*WW-1:0] mkline();
    logic [LW*WW-1:0] l;
    for (int i = 0; i < LW; i++) l[i*WW +: WW] = WW'(12'h100 + i * 12'h011);
    return l;
  endfunction

  task automatic drive_ind(input logic [GW-1:0] g, input logic [AW-1:0] pa, input logic ai,
                           input logic nl, input logic rv, input logic [LAW-1:0] rl,
                           input logic [LW*WW-1:0] rd);
    @(negedge clk);
    in_valid = 1; in_gen = g; need_ind = 1; ptr_addr = pa; autoinc = ai; need_load = nl;
    rsp_valid = rv; rsp_line = rl; rsp_data = rd; tag = tag + 1;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; rsp_valid = 0; need_ind = 0; restart = 0;
    ld_ready = 1; st_ready = 1; fwd_ready = 1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset fwd", fwd_valid, 0);
    chk("R1 reset take", {in_take, rsp_take, ld_valid, st_valid}, 0);
  endtask

  task automatic t_direct();
    @(negedge clk);
    in_valid = 1; in_gen = 0; need_ind = 0; need_load = 1; final_in = 15'h5123;
    rsp_valid = 1; rsp_line = 12'hABC; tag = 8'h3C;
    #1;
    chk("R10 passthrough addr", fwd_final, 15'h5123);
    chk("R10 no rsp consumed", rsp_take, 0);
    chk("R10 forwarded tag", fwd_tag, 8'h3C);
    chk("R9 load line", {ld_valid, ld_line}, {1'b1, 12'(15'h5123 >> 3)});
    chk("R10 no store", st_valid, 0);
    idle();
  endtask

  task automatic t_stall();
    drive_ind(0, 15'o00013, 0, 0, 0, 0, mkline());
    chk("R4 held", {in_take, fwd_valid, ld_valid, st_valid}, 0);
    @(negedge clk);
    rsp_valid = 1; rsp_line = 12'(15'o00013 >> 3); ld_ready = 0;
    #1;
    chk("R1 not ready", {in_take, rsp_take, fwd_valid}, 0);
    ld_ready = 1; st_ready = 0;
    #1;
    chk("R1 store not ready", {in_take, rsp_take, fwd_valid}, 0);
    idle();
  endtask

  task automatic t_mismatch();
    drive_ind(0, 15'o00013, 0, 0, 1, 12'(15'o00013 >> 3) + 1, mkline());
    chk("R5 rsp consumed", rsp_take, 1);
    chk("R5 no advance", {in_take, fwd_valid, ld_valid, st_valid}, 0);
    idle();
  endtask

  task automatic t_plain();
    dfield = 3'd5;
    drive_ind(0, 15'o20013, 0, 1, 1, 12'(15'o20013 >> 3), mkline());
    chk("R6 R8 final addr", fwd_final, {3'd5, 12'h133});
    chk("R6 advance", {in_take, rsp_take, fwd_valid}, 3'b111);
    chk("R7 no store w/o autoinc", st_valid, 0);
    chk("R9 load line", {ld_valid, ld_line}, {1'b1, 12'({3'd5, 12'h133} >> 3)});
    idle();
  endtask

  task automatic t_autoinc();
    logic [LW*WW-1:0] l;
    l = mkline(); l[0 +: WW] = 12'hFFF;
    dfield = 3'd2;
    drive_ind(0, 15'o01010, 1, 0, 1, 12'(15'o01010 >> 3), l);
    chk("R7 wrap final", fwd_final, {3'd2, 12'h000});
    chk("R7 store mask", {st_valid, st_mask}, {1'b1, 8'h01});
    chk("R7 store line", st_line, 12'(15'o01010 >> 3));
    chk("R7 store data", st_data, 96'h0);
    chk("R9 no load", ld_valid, 0);
    idle();
    l = mkline(); l[7*WW +: WW] = 12'h123;
    dfield = 3'd7;
    drive_ind(0, 15'o04017, 1, 1, 1, 12'(15'o04017 >> 3), l);
    chk("R7 incr final", fwd_final, {3'd7, 12'h124});
    chk("R7 top mask", st_mask, 8'h80);
    chk("R7 top data", st_data, {12'h124, 84'h0});
    chk("R9 load after incr", ld_line, 12'({3'd7, 12'h124} >> 3));
    idle();
  endtask

  task automatic t_gen();
    @(negedge clk);
    gen_global = 2;
    in_valid = 1; need_ind = 0; in_gen = 5; need_load = 1;
    #1;
    chk("R2 stale consumed", in_take, 1);
    chk("R2 stale nothing issued", {fwd_valid, ld_valid, st_valid}, 0);
    @(negedge clk);
    in_gen = 2;
    #1;
    chk("R3 global accepted", {fwd_valid, fwd_gen}, {1'b1, 4'd2});
    @(negedge clk);
    in_gen = 0;
    #1;
    chk("R3 old local now stale", {in_take, fwd_valid}, 2'b10);
    idle();
  endtask

  task automatic t_restart();
    @(negedge clk);
    gen_global = 3; restart = 1;
    @(negedge clk);
    restart = 0; gen_global = 4;
    in_valid = 1; need_ind = 0; in_gen = 3;
    #1;
    chk("R11 restart adopted global", {in_take, fwd_valid}, 2'b11);
    idle();
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_direct();
    t_stall();
    t_mismatch();
    t_plain();
    t_autoinc();
    t_gen();
    t_restart();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule